// File: doc/BRIEF.md
# Register Hazard Bubble Inserter

This block is a streaming stage placed in front of a short in-order pipeline that has no result forwarding. Each instruction arrives with an opaque instruction word and some sideband fields. The sideband fields are two optional source register indices, an optional destination register index, and a marker for label pseudo-instructions. The stage remembers the destinations of the last two real instructions it accepted. When a new instruction reads one of those registers, the stage places idle words (NOPs) on the output ahead of it, so that the downstream pipeline never reads a register before it has been written.

The number of NOPs depends on how far back the conflicting writer is. A hit on the newest writer costs two NOPs and a hit on the writer before it costs one. While the stage is emitting NOPs it holds the incoming instruction by keeping its input ready low. Both sides use valid/ready handshakes. The output word is registered and is held until the consumer takes it.

Top module: `hb_bubble_inserter`

## Requirements
- R1: A synchronous active-high reset clears out_valid, empties both history slots and cancels any NOPs still owed. After reset, in_ready is high while the output stage is empty, and an instruction that conflicted before the reset passes through with no NOP.
- R2: If an enabled source register equals the destination held in the newest history slot, exactly two NOP words are emitted before the instruction.
- R3: If an enabled source register matches only the older history slot, exactly one NOP word is emitted before the instruction.
- R4: Both source fields (in_src and in_srcb) are compared, each only when its enable flag is 1. A disabled field never causes a NOP.
- R5: When several matches apply, the larger NOP count is used, and all NOPs come out before the instruction word.
- R6: When a non-label instruction is accepted, the older slot takes the newest slot's content and the newest slot takes the instruction's destination. If in_dst_en is 0, the newest slot becomes empty.
- R7: An instruction with in_label = 1 is forwarded unchanged. It gets no NOPs, its source and destination fields are ignored, and it leaves both history slots unchanged.
- R8: Inserted NOPs never enter the history. Only the instruction that follows them shifts it.
- R9: An empty history slot matches no register index, including index 0.
- R10: While out_valid is 1 and out_ready is 0, out_word and out_valid hold. Every accepted word leaves exactly once, in order.
- R11: While NOPs are owed for the presented instruction, in_ready stays 0. With out_ready held at 1, the number of stall cycles equals the number of NOPs. An accepted instruction appears on out_word in the next cycle.
- R12: Each inserted NOP carries the value of the parameter NOP_WORD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream instruction valid |
| in_ready | output | 1 | Instruction accepted at this edge when in_valid is also 1 |
| in_word | input | WORD_W | Instruction word, forwarded unchanged |
| in_label | input | 1 | 1 marks a label pseudo-instruction |
| in_src_en | input | 1 | First source field present |
| in_src | input | REG_W | First source register index |
| in_srcb_en | input | 1 | Second source field present |
| in_srcb | input | REG_W | Second source register index |
| in_dst_en | input | 1 | Destination field present |
| in_dst | input | REG_W | Destination register index |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | WORD_W | Instruction word or NOP_WORD |

## Verification
The bound checker watches four properties on every cycle:
- the output word and valid hold under back-pressure;
- an accepted instruction shows up on the output one cycle later;
- a stalled input with a free output stage produces a NOP;
- the outputs are cleared after reset.

It also checks that no more than two NOPs are ever handed over in a row. Only the directed scenarios can show that the NOP count is correct for a given register pattern. That covers the distance rule and the selection of the larger count, the role of the enable flags, the transparency of labels, the exclusion of NOPs from the history, the behaviour of empty slots, and the cancelling of an owed bubble by reset. The scenarios compare the whole output stream against a model in the bench.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // Number of NOPs owed ahead of one instruction (0, 1 or 2)
  typedef logic [1:0] bub_t;
  localparam bub_t BUB_NONE = 2'd0;
  localparam bub_t BUB_ONE  = 2'd1;
  localparam bub_t BUB_TWO  = 2'd2;
endpackage

// File: rtl/hb_history.sv
module hb_history #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             dst_en,
  input  logic [REG_W-1:0] dst,
  output logic             new_v,
  output logic [REG_W-1:0] new_r,
  output logic             old_v,
  output logic [REG_W-1:0] old_r
);
  always_ff @(posedge clk) begin
    if (rst) begin
      new_v <= 1'b0;
      old_v <= 1'b0;
      new_r <= '0;
      old_r <= '0;
    end else if (shift) begin
      old_v <= new_v;
      old_r <= new_r;
      new_v <= dst_en;
      new_r <= dst;
    end
  end
endmodule

// File: rtl/hb_hazard_detect.sv
module hb_hazard_detect
  import hb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0]            src_en,
  input  logic [NSRC-1:0][REG_W-1:0] src,
  input  logic                       is_label,
  input  logic                       new_v,
  input  logic [REG_W-1:0]           new_r,
  input  logic                       old_v,
  input  logic [REG_W-1:0]           old_r,
  output bub_t                       need
);
  logic [NSRC-1:0] hit_new;
  logic [NSRC-1:0] hit_old;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit_new[i] = src_en[i] && new_v && (src[i] == new_r);
    assign hit_old[i] = src_en[i] && old_v && (src[i] == old_r);
  end

  always_comb begin
    if (is_label)       need = BUB_NONE;
    else if (|hit_new)  need = BUB_TWO;
    else if (|hit_old)  need = BUB_ONE;
    else                need = BUB_NONE;
  end
endmodule

// File: rtl/hb_out_stage.sv
module hb_out_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load && can_load) begin
      out_valid <= 1'b1;
      out_word  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hb_bubble_inserter.sv
module hb_bubble_inserter
  import hb_pkg::*;
#(
  parameter int                WORD_W   = 32,
  parameter int                REG_W    = 5,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_label,
  input  logic              in_src_en,
  input  logic [REG_W-1:0]  in_src,
  input  logic              in_srcb_en,
  input  logic [REG_W-1:0]  in_srcb,
  input  logic              in_dst_en,
  input  logic [REG_W-1:0]  in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  localparam int NSRC = 2;

  logic             h_new_v, h_old_v;
  logic [REG_W-1:0] h_new_r, h_old_r;
  bub_t             need;
  bub_t             sent;
  logic             can_load;
  logic             emit_nop;
  logic             fire_in;
  logic [WORD_W-1:0] next_word;

  hb_history #(.REG_W(REG_W)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .shift  (fire_in && !in_label),
    .dst_en (in_dst_en),
    .dst    (in_dst),
    .new_v  (h_new_v),
    .new_r  (h_new_r),
    .old_v  (h_old_v),
    .old_r  (h_old_r)
  );

  hb_hazard_detect #(.REG_W(REG_W), .NSRC(NSRC)) u_det (
    .src_en   ({in_srcb_en, in_src_en}),
    .src      ({in_srcb, in_src}),
    .is_label (in_label),
    .new_v    (h_new_v),
    .new_r    (h_new_r),
    .old_v    (h_old_v),
    .old_r    (h_old_r),
    .need     (need)
  );

  // NOPs already emitted for the instruction held at the input
  assign emit_nop  = in_valid && can_load && (sent < need);
  assign in_ready  = can_load && (sent >= need);
  assign fire_in   = in_valid && in_ready;
  assign next_word = emit_nop ? NOP_WORD : in_word;

  always_ff @(posedge clk) begin
    if (rst)           sent <= BUB_NONE;
    else if (fire_in)  sent <= BUB_NONE;
    else if (emit_nop) sent <= sent + 2'd1;
  end

  hb_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid),
    .word      (next_word),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );
endmodule

// File: rtl/hb_bubble_inserter_chk.sv
module hb_bubble_inserter_chk #(
  parameter int                WORD_W   = 32,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);
  // Consecutive NOP words handed downstream (assumes real words differ from NOP_WORD)
  logic [1:0] nop_run;
  always_ff @(posedge clk) begin
    if (rst) nop_run <= 2'd0;
    else if (out_valid && out_ready) begin
      if (out_word == NOP_WORD) nop_run <= (nop_run == 2'd3) ? 2'd3 : nop_run + 2'd1;
      else                      nop_run <= 2'd0;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  a_r11_accept_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_word == $past(in_word)));

  a_r11_stall_nop: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && (!out_valid || out_ready)) |=> (out_valid && out_word == NOP_WORD));

  a_r5_max_two: assert property (@(posedge clk) disable iff (rst) nop_run <= 2'd2);
endmodule

bind hb_bubble_inserter hb_bubble_inserter_chk #(
  .WORD_W   (WORD_W),
  .NOP_WORD (NOP_WORD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/sim_hb_bubble_inserter.sv
module sim_hb_bubble_inserter;
  localparam int WORD_W = 16;
  localparam int REG_W  = 3;
  localparam logic [WORD_W-1:0] NOP = 16'hA5A5;  // R12: NOP_WORD override

  typedef struct {
    logic [WORD_W-1:0] w;
    logic              lab;
    logic              se;
    logic [REG_W-1:0]  s;
    logic              be;
    logic [REG_W-1:0]  b;
    logic              de;
    logic [REG_W-1:0]  d;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [WORD_W-1:0] in_word = '0;
  logic in_label = 1'b0, in_src_en = 1'b0, in_srcb_en = 1'b0, in_dst_en = 1'b0;
  logic [REG_W-1:0] in_src = '0, in_srcb = '0, in_dst = '0;
  logic out_valid, out_ready;
  logic [WORD_W-1:0] out_word;

  int n_checks = 0, n_fail = 0;
  bit bp_mode = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic [WORD_W-1:0] got[$];
  logic [WORD_W-1:0] expq[$];
  ins_t seq[$];
  int stalls;

  always #4 clk = ~clk;  // 125 MHz

  hb_bubble_inserter #(.WORD_W(WORD_W), .REG_W(REG_W), .NOP_WORD(NOP)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .in_label(in_label), .in_src_en(in_src_en), .in_src(in_src), .in_srcb_en(in_srcb_en),
    .in_srcb(in_srcb), .in_dst_en(in_dst_en), .in_dst(in_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (out_valid && out_ready) got.push_back(out_word);
  end

  task automatic check(bit ok, string req, int act, int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic ins_t mk(int w, bit se, int s, bit be, int b, bit de, int d, bit lab);
    ins_t x;
    x.w = WORD_W'(w); x.se = se; x.s = REG_W'(s); x.be = be; x.b = REG_W'(b);
    x.de = de; x.d = REG_W'(d); x.lab = lab;
    return x;
  endfunction

  task automatic build_exp();
    bit nv = 0, ov = 0;
    logic [REG_W-1:0] nr = '0, orr = '0;
    expq.delete();
    foreach (seq[i]) begin
      int need = 0;
      if (!seq[i].lab) begin
        if ((seq[i].se && ov && seq[i].s == orr) || (seq[i].be && ov && seq[i].b == orr)) need = 1;
        if ((seq[i].se && nv && seq[i].s == nr) || (seq[i].be && nv && seq[i].b == nr)) need = 2;
      end
      for (int k = 0; k < need; k++) expq.push_back(NOP);
      expq.push_back(seq[i].w);
      if (!seq[i].lab) begin
        ov = nv; orr = nr; nv = seq[i].de; nr = seq[i].d;
      end
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic present(ins_t x);
    in_word = x.w; in_label = x.lab; in_src_en = x.se; in_src = x.s;
    in_srcb_en = x.be; in_srcb = x.b; in_dst_en = x.de; in_dst = x.d;
    in_valid = 1'b1;
  endtask

  task automatic run_seq(string req, bit bp);
    apply_reset();
    got.delete();
    build_exp();
    bp_mode = bp;
    stalls = 0;
    foreach (seq[i]) begin
      @(negedge clk);
      present(seq[i]);
      forever begin
        #2;
        if (in_ready) break;
        stalls++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    bp_mode = 1'b0;
    repeat (10) @(negedge clk);
    check(got.size() == expq.size(), req, got.size(), expq.size());
    foreach (expq[i])
      if (i < got.size()) check(got[i] == expq[i], req, got[i], expq[i]);
    if (!bp) check(stalls == expq.size() - seq.size(), "R11 stall cycles", stalls, expq.size() - seq.size());
  endtask

  task automatic t_reset();
    apply_reset();
    #2;
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_newest();  // R2
    seq = '{mk(16'h101,0,0,0,0,1,1,0), mk(16'h102,1,1,0,0,1,2,0)};
    run_seq("R2", 0);
  endtask

  task automatic t_older();  // R3
    seq = '{mk(16'h111,0,0,0,0,1,1,0), mk(16'h112,0,0,0,0,1,5,0), mk(16'h113,1,1,0,0,0,0,0)};
    run_seq("R3", 0);
  endtask

  task automatic t_flags();  // R4
    seq = '{mk(16'h121,0,0,0,0,1,3,0), mk(16'h122,0,3,0,3,1,4,0), mk(16'h123,1,7,1,4,0,0,0)};
    run_seq("R4", 0);
  endtask

  task automatic t_max();  // R5
    seq = '{mk(16'h131,0,0,0,0,1,1,0), mk(16'h132,0,0,0,0,1,2,0), mk(16'h133,1,1,1,2,0,0,0)};
    run_seq("R5", 0);
  endtask

  task automatic t_shift();  // R6
    seq = '{mk(16'h141,0,0,0,0,1,1,0), mk(16'h142,0,0,0,0,0,1,0),
            mk(16'h143,1,1,0,0,0,0,0), mk(16'h144,1,1,0,0,0,0,0)};
    run_seq("R6", 0);
  endtask

  task automatic t_label();  // R7
    seq = '{mk(16'h151,0,0,0,0,1,1,0), mk(16'h152,1,1,1,1,1,6,1), mk(16'h153,1,1,0,0,0,0,0)};
    run_seq("R7", 0);
  endtask

  task automatic t_nop_hist();  // R8
    seq = '{mk(16'h161,0,0,0,0,1,1,0), mk(16'h162,1,1,0,0,1,2,0), mk(16'h163,1,1,0,0,0,0,0)};
    run_seq("R8", 0);
  endtask

  task automatic t_empty();  // R9
    seq = '{mk(16'h171,1,0,1,0,1,0,0), mk(16'h172,1,0,0,0,0,0,0)};
    run_seq("R9", 0);
  endtask

  task automatic t_backpressure();  // R10
    seq.delete();
    for (int i = 0; i < 40; i++)
      seq.push_back(mk(16'h200 + i, (i % 3) != 0, i % 5, (i % 4) == 1, (i * 3) % 7,
                       (i % 6) != 2, (i * 5) % 6, (i % 9) == 4));
    run_seq("R10", 1);
  endtask

  task automatic t_reset_mid();  // R1: reset cancels an owed bubble
    ins_t a, b;
    a = mk(16'h181,0,0,0,0,1,1,0);
    b = mk(16'h182,1,1,0,0,0,0,0);
    apply_reset();
    @(negedge clk); present(a);
    #2; check(in_ready == 1'b1, "R1 first accept", in_ready, 1);
    @(negedge clk); present(b);
    #2; check(in_ready == 1'b0, "R2 stall before reset", in_ready, 0);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    #2; check(out_valid == 1'b0, "R1 out cleared", out_valid, 0);
    @(negedge clk); present(b);
    #2; check(in_ready == 1'b1, "R1 no owed NOP", in_ready, 1);
    @(negedge clk); in_valid = 1'b0;
    #2; check(out_valid && out_word == b.w, "R1 word after reset", out_word, b.w);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_newest();
        t_older();
        t_flags();
        t_max();
        t_shift();
        t_label();
        t_nop_hist();
        t_empty();
        t_backpressure();
        t_reset_mid();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule